// File: doc/BRIEF.md
# Bus Trace Capture Unit

This block observes one processor bus and records selected activity as trace frames in an on-chip circular buffer. Each frame holds a four-bit frame-type code, an address word, a data word and a 32-bit timestamp from a free-running counter. A mode register picks what counts as interesting: every bus cycle, only flow changes, only timer events, only writes that land inside a programmed address window, or only call, return and interrupt entry/exit points.

Capture is gated by a two-state controller. `ST_IDLE` holds capture off and leaves configuration open. A start trigger moves it to `ST_CAPTURE` (transition *arm*). A stop trigger moves it back to `ST_IDLE` (transition *disarm*), and stop wins when both triggers are high together. While idle, software configures the mode and window through an eight-entry register port. Writing the mode register also empties the buffer. Software then reads the buffer out, oldest frame first, by setting a frame index and reading the frame registers.

Register map (3-bit address): 0 mode (bits 2:0), 1 window low bound, 2 window high bound, 3 frame index, 4 frame address, 5 frame data, 6 frame timestamp, 7 info word. The info word holds the frame type in bits 3:0, the fill count in bits 10:4, the wrapped flag in bit 11 and the capturing flag in bit 12.

Top module: `bus_trace_unit`

## Requirements
- R1: After reset the unit is in `ST_IDLE`. The fill count is 0, the wrapped flag is 0, the capturing flag is 0, and the mode register reads 0.
- R2: A start trigger seen in `ST_IDLE` with stop low enters `ST_CAPTURE` at that edge, so frames are captured from the following cycle. A stop trigger in `ST_CAPTURE` returns to `ST_IDLE`, and the cycle in which stop is high is still captured. If start and stop are high together in `ST_IDLE`, the unit stays idle. Nothing is captured while idle.
- R3: Mode 0 (cycle) stores one frame per valid bus cycle. A read is type 0 and a write is type 1, and the frame carries the bus address and data. An invalid cycle stores nothing.
- R4: Mode 1 (flow) stores a type 2 frame holding the new target address only in a valid cycle whose flow-change flag is high. Sequential cycles store nothing.
- R5: Mode 2 (timer) stores a type 3 frame in every cycle where the event input is high. The frame's address and data are 0, and it ignores all bus activity.
- R6: Mode 3 (qualified write) stores a type 4 frame only for a valid write whose address lies between the low and high bounds, both bounds included. Reads and out-of-window writes store nothing.
- R7: Mode 4 (call/return) stores a frame for a valid cycle that carries a qualifier. The types are: interrupt entry 7, interrupt exit 8, call 5, return 6. When several qualifiers are high, they take priority in that order. A valid cycle with no qualifier, or an invalid cycle, stores nothing. Modes 5 to 7 store nothing.
- R8: The timestamp increases by one on every clock after reset. A frame carries the value present in the cycle it was captured.
- R9: The buffer holds 64 frames and the fill count stops at 64. A capture into a full buffer overwrites the oldest frame and sets the wrapped flag. Frame index 0 always selects the oldest stored frame.
- R10: Register writes are ignored in `ST_CAPTURE`. While capturing, the frame address, data and timestamp registers read 0. A mode write in `ST_IDLE` clears the fill count, the wrapped flag and the frame index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | 32 | Bus address or flow target |
| bus_data | input | 32 | Bus data |
| flow_chg | input | 1 | Execution flow changed this cycle |
| call_op | input | 1 | Call instruction qualifier |
| ret_op | input | 1 | Return instruction qualifier |
| irq_enter | input | 1 | Interrupt routine entry qualifier |
| irq_exit | input | 1 | Interrupt routine exit qualifier |
| event_in | input | 1 | Timer-mode event |
| trig_start | input | 1 | Start capture trigger |
| trig_stop | input | 1 | Stop capture trigger |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench builds the unit with its default parameters: 32-bit address, data and timestamp, and a depth of 64. With this depth, a 70-cycle burst overflows the buffer within a short run, which exposes the overwrite order, the saturating fill count and the wrapped flag. The 32-bit window bounds allow an inclusive-edge check one address below, on, and one address above each bound of the qualified-write mode.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_CAPTURE
    } trc_state_e;

    localparam logic [2:0] MODE_CYCLE   = 3'd0;
    localparam logic [2:0] MODE_FLOW    = 3'd1;
    localparam logic [2:0] MODE_TIMER   = 3'd2;
    localparam logic [2:0] MODE_QWRITE  = 3'd3;
    localparam logic [2:0] MODE_CALLRET = 3'd4;

    localparam logic [3:0] FT_READ     = 4'd0;
    localparam logic [3:0] FT_WRITE    = 4'd1;
    localparam logic [3:0] FT_FLOW     = 4'd2;
    localparam logic [3:0] FT_EVENT    = 4'd3;
    localparam logic [3:0] FT_QWRITE   = 4'd4;
    localparam logic [3:0] FT_CALL     = 4'd5;
    localparam logic [3:0] FT_RETURN   = 4'd6;
    localparam logic [3:0] FT_IRQ_IN   = 4'd7;
    localparam logic [3:0] FT_IRQ_OUT  = 4'd8;

    localparam logic [2:0] RA_MODE   = 3'd0;
    localparam logic [2:0] RA_WIN_LO = 3'd1;
    localparam logic [2:0] RA_WIN_HI = 3'd2;
    localparam logic [2:0] RA_INDEX  = 3'd3;
    localparam logic [2:0] RA_F_ADDR = 3'd4;
    localparam logic [2:0] RA_F_DATA = 3'd5;
    localparam logic [2:0] RA_F_TS   = 3'd6;
    localparam logic [2:0] RA_INFO   = 3'd7;

endpackage

// File: rtl/trc_stamp.sv
module trc_stamp #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] stamp
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stamp <= '0;
        else        stamp <= stamp + TW'(1);
    end
endmodule

// File: rtl/trc_select.sv
module trc_select
    import trc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [2:0]    mode,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          flow_chg,
    input  logic          call_op,
    input  logic          ret_op,
    input  logic          irq_enter,
    input  logic          irq_exit,
    input  logic          event_in,
    input  logic [AW-1:0] win_lo,
    input  logic [AW-1:0] win_hi,
    output logic          hit,
    output logic [3:0]    f_type,
    output logic [AW-1:0] f_addr,
    output logic [DW-1:0] f_data
);
    logic in_window;
    assign in_window = (bus_addr >= win_lo) && (bus_addr <= win_hi);

    always_comb begin
        hit    = 1'b0;
        f_type = FT_READ;
        f_addr = bus_addr;
        f_data = bus_data;
        case (mode)
            MODE_CYCLE: begin
                hit    = bus_valid;
                f_type = bus_write ? FT_WRITE : FT_READ;
            end
            MODE_FLOW: begin
                hit    = bus_valid && flow_chg;
                f_type = FT_FLOW;
            end
            MODE_TIMER: begin
                hit    = event_in;
                f_type = FT_EVENT;
                f_addr = '0;
                f_data = '0;
            end
            MODE_QWRITE: begin
                hit    = bus_valid && bus_write && in_window;
                f_type = FT_QWRITE;
            end
            MODE_CALLRET: begin
                hit = bus_valid && (irq_enter || irq_exit || call_op || ret_op);
                if (irq_enter)     f_type = FT_IRQ_IN;
                else if (irq_exit) f_type = FT_IRQ_OUT;
                else if (call_op)  f_type = FT_CALL;
                else               f_type = FT_RETURN;
            end
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/trc_ring.sv
module trc_ring #(
    parameter int DEPTH = 64,
    parameter int FW    = 100,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [FW-1:0] din,
    input  logic [PW-1:0] rd_idx,
    output logic [FW-1:0] dout,
    output logic [PW:0]   fill,
    output logic          wrapped
);
    logic [FW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] wr_nxt;
    logic [PW-1:0] oldest;
    logic [PW:0]   sum;
    logic [PW-1:0] phys;
    logic          full;

    assign full   = (fill == (PW+1)'(DEPTH));
    assign wr_nxt = (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + PW'(1);
    assign oldest = full ? wr_ptr : '0;
    assign sum    = {1'b0, oldest} + {1'b0, rd_idx};
    assign phys   = (sum >= (PW+1)'(DEPTH)) ? PW'(sum - (PW+1)'(DEPTH)) : PW'(sum);
    assign dout   = mem[phys];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            fill    <= '0;
            wrapped <= 1'b0;
        end else if (clear) begin
            wr_ptr  <= '0;
            fill    <= '0;
            wrapped <= 1'b0;
        end else if (push) begin
            wr_ptr <= wr_nxt;
            if (full) wrapped <= 1'b1;
            else      fill    <= fill + (PW+1)'(1);
        end
    end
endmodule

// File: rtl/bus_trace_unit.sv
module bus_trace_unit
    import trc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TW    = 32,
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_data,
    input  logic        flow_chg,
    input  logic        call_op,
    input  logic        ret_op,
    input  logic        irq_enter,
    input  logic        irq_exit,
    input  logic        event_in,
    input  logic        trig_start,
    input  logic        trig_stop,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    localparam int PW = $clog2(DEPTH);
    localparam int FW = 4 + AW + DW + TW;
    localparam int RW = 32;

    trc_state_e    state_q, state_d;
    logic          running, cfg_open;
    logic [2:0]    mode_q;
    logic [AW-1:0] win_lo_q, win_hi_q;
    logic [PW-1:0] rd_idx_q;
    logic [TW-1:0] stamp;
    logic          hit, push, clear;
    logic [3:0]    s_type;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;
    logic [FW-1:0] frame_in, frame_out;
    logic [PW:0]   fill;
    logic          wrapped;
    logic [3:0]    o_type;
    logic [AW-1:0] o_addr;
    logic [DW-1:0] o_data;
    logic [TW-1:0] o_ts;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: arm on start (stop wins), disarm on stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (trig_start && !trig_stop) state_d = ST_CAPTURE;
            ST_CAPTURE: if (trig_stop)                state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        running  = 1'b0;
        cfg_open = 1'b0;
        unique case (state_q)
            ST_IDLE:    cfg_open = 1'b1;
            ST_CAPTURE: running  = 1'b1;
        endcase
    end

    assign clear = reg_we && cfg_open && (reg_addr == RA_MODE);
    assign push  = running && hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_CYCLE;
            win_lo_q <= '0;
            win_hi_q <= '0;
            rd_idx_q <= '0;
        end else if (reg_we && cfg_open) begin
            case (reg_addr)
                RA_MODE: begin
                    mode_q   <= reg_wdata[2:0];
                    rd_idx_q <= '0;
                end
                RA_WIN_LO: win_lo_q <= AW'(reg_wdata);
                RA_WIN_HI: win_hi_q <= AW'(reg_wdata);
                RA_INDEX:  rd_idx_q <= reg_wdata[PW-1:0];
                default: ;
            endcase
        end
    end

    trc_stamp #(.TW(TW)) u_stamp (
        .clk   (clk),
        .rst_n (rst_n),
        .stamp (stamp)
    );

    trc_select #(.AW(AW), .DW(DW)) u_select (
        .mode      (mode_q),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (AW'(bus_addr)),
        .bus_data  (DW'(bus_data)),
        .flow_chg  (flow_chg),
        .call_op   (call_op),
        .ret_op    (ret_op),
        .irq_enter (irq_enter),
        .irq_exit  (irq_exit),
        .event_in  (event_in),
        .win_lo    (win_lo_q),
        .win_hi    (win_hi_q),
        .hit       (hit),
        .f_type    (s_type),
        .f_addr    (s_addr),
        .f_data    (s_data)
    );

    assign frame_in = {s_type, s_addr, s_data, stamp};

    trc_ring #(.DEPTH(DEPTH), .FW(FW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .push    (push),
        .din     (frame_in),
        .rd_idx  (rd_idx_q),
        .dout    (frame_out),
        .fill    (fill),
        .wrapped (wrapped)
    );

    assign {o_type, o_addr, o_data, o_ts} = frame_out;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_MODE:   reg_rdata = RW'(mode_q);
            RA_WIN_LO: reg_rdata = RW'(win_lo_q);
            RA_WIN_HI: reg_rdata = RW'(win_hi_q);
            RA_INDEX:  reg_rdata = RW'(rd_idx_q);
            RA_F_ADDR: reg_rdata = running ? '0 : RW'(o_addr);
            RA_F_DATA: reg_rdata = running ? '0 : RW'(o_data);
            RA_F_TS:   reg_rdata = running ? '0 : RW'(o_ts);
            RA_INFO:   reg_rdata = RW'({running, wrapped, fill, running ? 4'd0 : o_type});
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
    parameter int DEPTH  = 64,
    parameter int FILL_W = 7,
    parameter int TW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              running,
    input logic [FILL_W-1:0] fill,
    input logic              wrapped,
    input logic [TW-1:0]     stamp,
    input logic [2:0]        mode
);
    assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH));

    assert_wrap_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrapped) |-> ($past(fill) == FILL_W'(DEPTH)));

    assert_stamp_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (stamp == $past(stamp) + TW'(1)));

    assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(mode));

    assert_idle_no_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (fill == '0 || $stable(fill)));
endmodule

bind bus_trace_unit trc_checker #(.DEPTH(DEPTH), .FILL_W(PW+1), .TW(TW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (running),
    .fill    (fill),
    .wrapped (wrapped),
    .stamp   (stamp),
    .mode    (mode_q)
);

// File: tb/sim_bus_trace_unit.sv
module sim_bus_trace_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 0, bus_write = 0, flow_chg = 0;
    logic        call_op = 0, ret_op = 0, irq_enter = 0, irq_exit = 0, event_in = 0;
    logic        trig_start = 0, trig_stop = 0, reg_we = 0;
    logic [31:0] bus_addr = 0, bus_data = 0, reg_wdata = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bus_trace_unit u0 (.*);

    // vector: mode[47:45] ctl[44:37] (valid,write,flow,call,ret,irq_in,irq_out,event) cap[36] type[35:32] addr[31:0]
    function automatic logic [47:0] tv(input logic [2:0] m, input logic [7:0] ctl,
                                       input logic cp, input logic [3:0] ty, input logic [31:0] a);
        return {m, ctl, cp, ty, a};
    endfunction

    localparam int NV = 17;
    localparam logic [47:0] TBL [NV] = '{
        tv(3'd0, 8'b1000_0000, 1'b1, 4'd0, 32'h0000_2000),
        tv(3'd0, 8'b1100_0000, 1'b1, 4'd1, 32'h0000_2004),
        tv(3'd0, 8'b0100_0000, 1'b0, 4'd0, 32'h0000_2008),
        tv(3'd1, 8'b1010_0000, 1'b1, 4'd2, 32'h0000_3000),
        tv(3'd1, 8'b1000_0000, 1'b0, 4'd0, 32'h0000_3004),
        tv(3'd2, 8'b0000_0001, 1'b1, 4'd3, 32'h0000_0000),
        tv(3'd2, 8'b1100_0000, 1'b0, 4'd0, 32'h0000_1000),
        tv(3'd3, 8'b1100_0000, 1'b1, 4'd4, 32'h0000_1000),
        tv(3'd3, 8'b1100_0000, 1'b0, 4'd0, 32'h0000_1100),
        tv(3'd3, 8'b1000_0000, 1'b0, 4'd0, 32'h0000_1010),
        tv(3'd3, 8'b1100_0000, 1'b1, 4'd4, 32'h0000_10FF),
        tv(3'd4, 8'b1001_0000, 1'b1, 4'd5, 32'h0000_4000),
        tv(3'd4, 8'b1000_1000, 1'b1, 4'd6, 32'h0000_4004),
        tv(3'd4, 8'b1001_0100, 1'b1, 4'd7, 32'h0000_4008),
        tv(3'd4, 8'b1000_0010, 1'b1, 4'd8, 32'h0000_400C),
        tv(3'd4, 8'b0001_0000, 1'b0, 4'd0, 32'h0000_4010),
        tv(3'd3, 8'b1100_0000, 1'b0, 4'd0, 32'h0000_0FFF)
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic bus_idle();
        bus_valid = 0; bus_write = 0; flow_chg = 0; call_op = 0; ret_op = 0;
        irq_enter = 0; irq_exit = 0; event_in = 0; bus_addr = 0; bus_data = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv, t62, t63;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        reg_rd(3'd7, rv); check("R1 info", rv, 32'h0);
        reg_rd(3'd0, rv); check("R1 mode", rv, 32'h0);
        reg_wr(3'd1, 32'h0000_1000);
        reg_wr(3'd2, 32'h0000_10FF);

        // table walk: modes R3..R7 and window edges R6
        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            logic [31:0] exp_d;
            v = TBL[i];
            reg_wr(3'd0, {29'd0, v[47:45]});
            trig_start = 1;
            @(negedge clk);
            trig_start = 0;
            {bus_valid, bus_write, flow_chg, call_op, ret_op, irq_enter, irq_exit, event_in} = v[44:37];
            bus_addr = v[31:0];
            bus_data = v[31:0] ^ 32'hFFFF_0000;
            trig_stop = 1;
            @(negedge clk);
            trig_stop = 0;
            bus_idle();
            reg_rd(3'd7, rv);
            check($sformatf("R3-R7 vec%0d fill", i), {25'd0, rv[10:4]}, {31'd0, v[36]});
            if (v[36]) begin
                exp_d = (v[47:45] == 3'd2) ? 32'h0 : (v[31:0] ^ 32'hFFFF_0000);
                check($sformatf("R3 R4 R5 R6 R7 vec%0d type", i), {28'd0, rv[3:0]}, {28'd0, v[35:32]});
                reg_rd(3'd4, rv);
                check($sformatf("R3 R4 R5 R6 R7 vec%0d addr", i), rv, v[31:0]);
                reg_rd(3'd5, rv);
                check($sformatf("R3 R5 vec%0d data", i), rv, exp_d);
            end
        end

        // R2: start and stop together -> stays idle, nothing captured
        reg_wr(3'd0, 32'd0);
        trig_start = 1; trig_stop = 1; bus_valid = 1; bus_addr = 32'h77;
        @(negedge clk);
        trig_start = 0; trig_stop = 0;
        @(negedge clk);
        bus_idle();
        reg_rd(3'd7, rv);
        check("R2 stop wins running", {31'd0, rv[12]}, 32'd0);
        check("R2 stop wins fill", {25'd0, rv[10:4]}, 32'd0);

        // R2/R10: visibility and ignored writes while capturing
        reg_wr(3'd0, 32'd0);
        trig_start = 1;
        @(negedge clk);
        trig_start = 0;
        reg_rd(3'd7, rv);
        check("R2 running flag", {31'd0, rv[12]}, 32'd1);
        bus_valid = 1; bus_addr = 32'h55; bus_data = 32'hA5;
        reg_we = 1; reg_addr = 3'd0; reg_wdata = 32'd3;
        @(negedge clk);
        bus_idle(); reg_we = 0;
        reg_rd(3'd4, rv);
        check("R10 frame hidden while capturing", rv, 32'h0);
        trig_stop = 1;
        @(negedge clk);
        trig_stop = 0;
        reg_rd(3'd0, rv);
        check("R10 mode write ignored", rv, 32'd0);
        reg_rd(3'd7, rv);
        check("R10 fill after ignored write", {25'd0, rv[10:4]}, 32'd1);
        reg_rd(3'd4, rv);
        check("R2 first captured frame", rv, 32'h55);

        // R9/R8: wrap with 70 frames
        reg_wr(3'd0, 32'd0);
        trig_start = 1;
        @(negedge clk);
        trig_start = 0;
        for (int k = 0; k < 70; k++) begin
            bus_valid = 1; bus_addr = k; bus_data = k;
            trig_stop = (k == 69);
            @(negedge clk);
        end
        trig_stop = 0;
        bus_idle();
        reg_rd(3'd7, rv);
        check("R9 fill saturates", {25'd0, rv[10:4]}, 32'd64);
        check("R9 wrapped set", {31'd0, rv[11]}, 32'd1);
        reg_rd(3'd4, rv); check("R9 oldest frame", rv, 32'd6);
        reg_wr(3'd3, 32'd10);
        reg_rd(3'd4, rv); check("R9 index 10", rv, 32'd16);
        reg_wr(3'd3, 32'd63);
        reg_rd(3'd4, rv); check("R9 newest frame", rv, 32'd69);
        reg_rd(3'd6, t63);
        reg_wr(3'd3, 32'd62);
        reg_rd(3'd6, t62);
        check("R8 stamp step", t63 - t62, 32'd1);

        // R10: mode write clears
        reg_wr(3'd0, 32'd2);
        reg_rd(3'd7, rv);
        check("R10 clear fill", {25'd0, rv[10:4]}, 32'd0);
        check("R10 clear wrapped", {31'd0, rv[11]}, 32'd0);

        // R5/R8: timer events three cycles apart
        trig_start = 1;
        @(negedge clk);
        trig_start = 0;
        event_in = 1; @(negedge clk); event_in = 0;
        @(negedge clk); @(negedge clk);
        event_in = 1; trig_stop = 1; @(negedge clk);
        event_in = 0; trig_stop = 0;
        reg_rd(3'd7, rv);
        check("R5 two events", {25'd0, rv[10:4]}, 32'd2);
        reg_rd(3'd6, t62);
        reg_wr(3'd3, 32'd1);
        reg_rd(3'd6, t63);
        check("R8 stamp spacing", t63 - t62, 32'd3);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule